// File: doc/BRIEF.md
# Age-Locked Exception Capture Register

This block keeps one record of an excepting instruction: a data word and the age tag of the instruction that produced it. The block has a single storage level and a lock bit. While the lock is open, any exception report is written and the lock closes. While the lock is closed, a report replaces the contents only if its instruction is strictly older than the current owner. As a result, the oldest outstanding exception is the one kept.

A kill report carries the tag of the oldest instruction that the pipeline discards. If that instruction is the owner, or is older than the owner, the lock opens again. The stored word and tag stay in place so that they can still be read. Age tags are sequence numbers that wrap around. Age is decided by the sign of the modular difference of two tags.

When a kill and an exception report arrive in the same cycle, the kill is applied first. The exception is then judged against the state that results.

Top module: `exc_capture_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `locked` at 0 and both `cap_data` and `cap_tag` at zero.
- R2: While `locked` is 0, an exception report (`exc_valid` = 1) stores `exc_data` and `exc_tag`, and `locked` reads 1 from the next cycle on.
- R3: While `locked` is 1, an exception report whose tag is strictly older than `cap_tag` replaces both data and tag, and `locked` stays 1. Tag a is older than tag b when the 8-bit value (a - b) mod 256 has its top bit set.
- R4: While `locked` is 1, an exception report whose tag equals `cap_tag` or is younger than it leaves `cap_data` and `cap_tag` unchanged.
- R5: While `locked` is 1, a kill (`kill_valid` = 1) whose `kill_tag` equals `cap_tag` or is older than it (the value (kill_tag - cap_tag) mod 256 is zero or has its top bit set) makes `locked` read 0 in the next cycle.
- R6: While `locked` is 1, a kill whose tag is younger than `cap_tag` leaves `locked` at 1.
- R7: When a qualifying kill and an exception report arrive in the same cycle, the kill is applied first. The exception is then captured as though the lock were open, and `locked` reads 1.
- R8: `cap_data` and `cap_tag` change only when an exception is captured. Unlocking keeps their values.
- R9: The age comparison wraps around. For example, tag 0xFE is older than tag 0x02, and tag 0x02 is younger than 0xFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid | input | 1 | Exception report present |
| exc_data | input | DATA_W | Data word of the excepting instruction |
| exc_tag | input | TAG_W | Age tag of the excepting instruction |
| kill_valid | input | 1 | Kill report present |
| kill_tag | input | TAG_W | Age tag of the oldest killed instruction |
| cap_data | output | DATA_W | Captured data word |
| cap_tag | output | TAG_W | Tag of the instruction that owns the contents |
| locked | output | 1 | Lock status (1 = locked) |

## Verification
The assertions check the following on every cycle: capture while the lock is open, capture of an older report while locked, that equal or younger reports are ignored when no kill is present, that a qualifying kill unlocks, that the lock holds when no kill arrives, and that the data and tag stay fixed when no exception is reported. The bench sweeps a spread of owner tags against every possible exception tag and every possible kill tag. This sweep shows that the age ordering is correct across the wrap point. It also exposes the ordering when a kill and an exception arrive in the same cycle, and the reset values, which only these concrete scenarios can show.

// File: rtl/excap_pkg.sv
package excap_pkg;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

endpackage

// File: rtl/excap_age_cmp.sv
// Modular age comparison of two wrapping sequence tags.
module excap_age_cmp #(
    parameter int TAG_W = 8
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             a_older,
    output logic             a_equal
);
    logic [TAG_W-1:0] diff;

    always_comb begin
        diff    = tag_a - tag_b;
        a_older = diff[TAG_W-1];
        a_equal = (diff == '0);
    end
endmodule

// File: rtl/excap_ctrl.sv
// Lock state machine and single-level storage, two-process style.
module excap_ctrl
    import excap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [DATA_W-1:0] exc_data,
    input  logic [TAG_W-1:0]  exc_tag,
    input  logic              kill_valid,
    input  logic              exc_is_older,
    input  logic              kill_is_older,
    input  logic              kill_is_equal,
    output logic [DATA_W-1:0] cap_data,
    output logic [TAG_W-1:0]  cap_tag,
    output lock_state_e       state
);
    typedef struct packed {
        lock_state_e       st;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } cap_reg_t;

    cap_reg_t reg_d, reg_q;
    logic     kill_hit;
    logic     still_locked;
    logic     take_exc;

    always_comb begin
        reg_d        = reg_q;
        // Kill is resolved first; the exception is judged afterwards.
        kill_hit     = kill_valid && (kill_is_older || kill_is_equal);
        still_locked = (reg_q.st == ST_LOCKED) && !kill_hit;
        take_exc     = exc_valid && (!still_locked || exc_is_older);
        if (!still_locked) begin
            reg_d.st = ST_OPEN;
        end
        if (take_exc) begin
            reg_d.st   = ST_LOCKED;
            reg_d.data = exc_data;
            reg_d.tag  = exc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign cap_data = reg_q.data;
    assign cap_tag  = reg_q.tag;
    assign state    = reg_q.st;
endmodule

// File: rtl/exc_capture_reg.sv
module exc_capture_reg
    import excap_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [DATA_W-1:0] exc_data,
    input  logic [TAG_W-1:0]  exc_tag,
    input  logic              kill_valid,
    input  logic [TAG_W-1:0]  kill_tag,
    output logic [DATA_W-1:0] cap_data,
    output logic [TAG_W-1:0]  cap_tag,
    output logic              locked
);
    localparam int NUM_CMP = 2;

    lock_state_e      state;
    logic [TAG_W-1:0] owner_tag;
    logic [TAG_W-1:0] probe_tag [NUM_CMP];
    logic             probe_older [NUM_CMP];
    logic             probe_equal [NUM_CMP];

    assign probe_tag[0] = exc_tag;
    assign probe_tag[1] = kill_tag;

    // One comparator per incoming tag, each against the owner tag.
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        excap_age_cmp #(.TAG_W(TAG_W)) u_cmp (
            .tag_a  (probe_tag[i]),
            .tag_b  (owner_tag),
            .a_older(probe_older[i]),
            .a_equal(probe_equal[i])
        );
    end

    logic unused_eq;
    assign unused_eq = probe_equal[0];

    excap_ctrl #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .exc_valid    (exc_valid),
        .exc_data     (exc_data),
        .exc_tag      (exc_tag),
        .kill_valid   (kill_valid),
        .exc_is_older (probe_older[0]),
        .kill_is_older(probe_older[1]),
        .kill_is_equal(probe_equal[1]),
        .cap_data     (cap_data),
        .cap_tag      (owner_tag),
        .state        (state)
    );

    assign cap_tag = owner_tag;
    assign locked  = (state == ST_LOCKED);
endmodule

// File: rtl/excap_chk.sv
module excap_chk #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_valid,
    input logic [DATA_W-1:0] exc_data,
    input logic [TAG_W-1:0]  exc_tag,
    input logic              kill_valid,
    input logic [TAG_W-1:0]  kill_tag,
    input logic [DATA_W-1:0] cap_data,
    input logic [TAG_W-1:0]  cap_tag,
    input logic              locked
);
    logic [TAG_W-1:0] exc_gap;
    logic [TAG_W-1:0] kill_gap;
    logic             exc_before;
    logic             kill_reaches;

    assign exc_gap      = exc_tag - cap_tag;
    assign kill_gap     = kill_tag - cap_tag;
    assign exc_before   = exc_gap[TAG_W-1];
    assign kill_reaches = kill_gap[TAG_W-1] || (kill_gap == '0);

    AST_OPEN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!locked && exc_valid) |=> (locked && cap_data == $past(exc_data) && cap_tag == $past(exc_tag))); // R2

    AST_OLDER_REPLACES: assert property (@(posedge clk) disable iff (rst)
        (locked && exc_valid && exc_before) |=> (locked && cap_tag == $past(exc_tag) && cap_data == $past(exc_data))); // R3

    AST_YOUNGER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (locked && exc_valid && !exc_before && !kill_valid) |=> ($stable(cap_data) && $stable(cap_tag) && locked)); // R4

    AST_KILL_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (locked && kill_valid && kill_reaches && !exc_valid) |=> !locked); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (locked && !kill_valid) |=> locked); // R6

    AST_KEEP_CONTENTS: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> ($stable(cap_data) && $stable(cap_tag))); // R8
endmodule

bind exc_capture_reg excap_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .exc_valid (exc_valid),
    .exc_data  (exc_data),
    .exc_tag   (exc_tag),
    .kill_valid(kill_valid),
    .kill_tag  (kill_tag),
    .cap_data  (cap_data),
    .cap_tag   (cap_tag),
    .locked    (locked)
);

// File: tb/sim_exc_capture_reg.sv
`timescale 1ns/1ps
module sim_exc_capture_reg;
    localparam int DW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          exc_valid = 1'b0;
    logic [DW-1:0] exc_data = '0;
    logic [TW-1:0] exc_tag = '0;
    logic          kill_valid = 1'b0;
    logic [TW-1:0] kill_tag = '0;
    logic [DW-1:0] cap_data;
    logic [TW-1:0] cap_tag;
    logic          locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state, built from the requirements.
    bit            m_lock = 1'b0;
    logic [DW-1:0] m_data = '0;
    logic [TW-1:0] m_tag  = '0;

    always #10 clk = ~clk;

    exc_capture_reg #(.DATA_W(DW), .TAG_W(TW)) u0 (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_data(exc_data),
        .exc_tag(exc_tag), .kill_valid(kill_valid), .kill_tag(kill_tag),
        .cap_data(cap_data), .cap_tag(cap_tag), .locked(locked)
    );

    function automatic bit is_older(input int a, input int b);
        int d;
        d = (a - b + 512) % 256;
        return d >= 128;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, {63'd0, locked}, {63'd0, m_lock});
        check(req, {32'd0, cap_data}, {32'd0, m_data});
        check(req, {56'd0, cap_tag}, {56'd0, m_tag});
    endtask

    // One clock with given inputs; model updated by the spec rules; sample after edge.
    task automatic cycle(input bit ev, input int et, input logic [DW-1:0] ed,
                         input bit kv, input int kt);
        bit lk;
        exc_valid  = ev;
        exc_tag    = et[TW-1:0];
        exc_data   = ed;
        kill_valid = kv;
        kill_tag   = kt[TW-1:0];
        @(posedge clk);
        lk = m_lock;
        if (kv && lk && (is_older(kt, m_tag) || kt[TW-1:0] == m_tag)) lk = 1'b0;
        if (ev && (!lk || is_older(et, m_tag))) begin
            lk = 1'b1; m_data = ed; m_tag = et[TW-1:0];
        end
        m_lock = lk;
        #2;
        exc_valid  = 1'b0;
        kill_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int b);
        return {a[7:0], b[7:0], ~a[7:0], b[7:0] ^ 8'h5A};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1: reset state
        check("R1 lock", {63'd0, locked}, 64'd0);
        check("R1 data", {32'd0, cap_data}, 64'd0);
        check("R1 tag", {56'd0, cap_tag}, 64'd0);

        // Exception-tag sweep against spread owner tags.
        for (int o = 0; o < 256; o += 17) begin
            for (int t = 0; t < 256; t++) begin
                cycle(1'b0, 0, '0, 1'b1, m_tag);          // unlock via owner kill
                check_all("R5/R8 unlock keeps data");
                cycle(1'b1, o, pat(o, 1), 1'b0, 0);
                check_all("R2 open capture");
                cycle(1'b1, t, pat(o, t), 1'b0, 0);
                if (is_older(t, o)) check_all("R3/R9 older replaces");
                else                check_all("R4/R9 younger ignored");
            end
        end

        // Kill-tag sweep against spread owner tags.
        for (int o = 3; o < 256; o += 23) begin
            for (int k = 0; k < 256; k++) begin
                cycle(1'b0, 0, '0, 1'b1, m_tag);
                cycle(1'b1, o, pat(k, o), 1'b0, 0);
                cycle(1'b0, 0, '0, 1'b1, k);
                if (is_older(k, o) || k == o) check_all("R5 kill unlocks");
                else                          check_all("R6 younger kill ignored");
            end
        end

        // Wrap point spot checks.
        cycle(1'b0, 0, '0, 1'b1, m_tag);
        cycle(1'b1, 2, 32'hAAAA0002, 1'b0, 0);
        cycle(1'b1, 254, 32'hBBBB00FE, 1'b0, 0);
        check("R9 0xFE older than 0x02", {56'd0, cap_tag}, 64'hFE);
        cycle(1'b1, 2, 32'hCCCC0002, 1'b0, 0);
        check("R9 0x02 younger than 0xFE", {32'd0, cap_data}, 64'hBBBB00FE);

        // Same-cycle kill and exception: kill first, then capture.
        for (int o = 0; o < 256; o += 5) begin
            cycle(1'b0, 0, '0, 1'b1, m_tag);
            cycle(1'b1, o, pat(o, 7), 1'b0, 0);
            cycle(1'b1, (o + 9) % 256, pat(o, 9), 1'b1, o);
            check_all("R7 kill then capture");
            check("R7 younger taken after kill", {56'd0, cap_tag}, {56'd0, 8'((o + 9) % 256)});
            check("R7 relocked", {63'd0, locked}, 64'd1);
        end

        // Reset from a locked state.
        cycle(1'b1, 77, 32'h12345678, 1'b0, 0);
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        m_lock = 1'b0; m_data = '0; m_tag = '0;
        check_all("R1 reset from locked");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule